// File: doc/BRIEF.md
# Four-Channel Hit Sequencer for a Shared Time Encoder

This block lets four time-to-digital channels feed one fine-time encoder and one zero-suppressing buffer. Each channel has a fast sample register that captures its delay-line tap vector on every fast clock edge. When the hit flag that goes with a channel's taps is high, that channel stops sampling and keeps its captured pattern for one full frame. A frame is `NCH` slow cycles, and each slow cycle is `RATIO` fast cycles. With the defaults, this is 16 cycles of a 250 MHz clock, which is 64 ns.

All later stages run at the slow rate. They are built as clock-enabled logic on the fast clock, paced by a phase counter that starts from reset. Once per frame, a chain of slot registers loads every channel's frozen flag and pattern in parallel. For the rest of the frame the chain acts as a shift path that moves one slot per slow cycle toward the encoder side. The block presents each slot that holds a hit as a one-cycle strobe that carries the channel number and the pattern. It drops slots that hold no hit.

Top module: `hit_share_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `out_valid` is 0. Reset also clears `out_chan` and `out_pat` to 0.
- R2: A channel samples only while it is open. If its hit bit is high at an open edge E, the channel captures its taps and stays closed for the next FRAME-1 edges, where FRAME = NCH*RATIO. It opens again at edge E+FRAME. A hit seen at E+1 through E+FRAME-1 is ignored, and a hit seen at E+FRAME is captured.
- R3: The pattern reported for a hit equals the channel's taps at its capture edge, whatever the taps do afterwards.
- R4: Fast edges are numbered from 0, starting at the first edge after reset is released. Load edges are the edges whose number is FRAME-1 modulo FRAME. A hit captured at edge E is loaded at the first load edge after E, and it is reported exactly once.
- R5: Channel c's slot is reported at load edge + RATIO*(c+1). Slots therefore leave in ascending channel order, one per slow cycle, and strobes are at least RATIO fast cycles apart.
- R6: `out_valid` is high for exactly one fast cycle per reported hit. During that cycle, `out_chan` holds the channel index in binary and `out_pat` holds the pattern. Both hold their values between strobes.
- R7: A slot with no hit produces no strobe. If no hit arrives, `out_valid` never rises.
- R8: When all channels hit on the same edge, all four hits are reported within the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | NCH | Per-channel hit flag qualifying the taps |
| taps_i | input | NCH*TAP_W | Tap vectors, channel c in bits [c*TAP_W +: TAP_W] |
| out_valid | output | 1 | One-cycle strobe to the encoder |
| out_chan | output | CW | Channel index of the reported hit |
| out_pat | output | TAP_W | Frozen tap pattern of the reported hit |

## Verification
The bench builds the block with NCH=4, TAP_W=16 and RATIO=4. This makes a frame 16 fast cycles long, so every capture phase inside a frame, including the last phase before a load edge, can be reached within a few hundred cycles. With four channels, the bench can exercise full contention on one frame, the ordering of slots along the shift path, and the re-hit boundary at exactly one frame. The 16-bit patterns make a corrupted or stale pattern easy to tell apart from the expected one.

// File: rtl/hit_share_pkg.sv
package hit_share_pkg;

  typedef enum logic [1:0] {
    XFER_HOLD  = 2'd0,
    XFER_SHIFT = 2'd1,
    XFER_LOAD  = 2'd2
  } xfer_mode_e;

  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hit_share_phase.sv
module hit_share_phase
  import hit_share_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  output logic slow_en,
  output logic load_en
);
  localparam int PW = safe_clog2(RATIO);
  localparam int SW = safe_clog2(NCH);

  logic [PW-1:0] ph_q;
  logic [SW-1:0] sl_q;

  always_comb begin
    slow_en = (ph_q == PW'(RATIO - 1));
    load_en = slow_en && (sl_q == SW'(NCH - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
      sl_q <= '0;
    end else begin
      if (slow_en) begin
        ph_q <= '0;
        sl_q <= (sl_q == SW'(NCH - 1)) ? '0 : sl_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hit_share_sampler.sv
module hit_share_sampler
  import hit_share_pkg::*;
#(
  parameter int TAP_W = 16,
  parameter int FRAME = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic [TAP_W-1:0] taps_i,
  output logic             open_o,
  output logic             frozen_o,
  output logic [TAP_W-1:0] pat_o
);
  localparam int CNTW = safe_clog2(FRAME);

  logic            frz_q;
  logic [CNTW-1:0] left_q;

  assign open_o   = !frz_q || (left_q == '0);
  assign frozen_o = frz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frz_q  <= 1'b0;
      left_q <= '0;
      pat_o  <= '0;
    end else if (open_o) begin
      pat_o  <= taps_i;
      frz_q  <= hit_i;
      left_q <= CNTW'(FRAME - 1);
    end else begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/hit_share_chain.sv
module hit_share_chain
  import hit_share_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int TAP_W = 16,
  parameter int CW    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slow_en,
  input  logic                 load_en,
  input  logic [NCH-1:0]       frozen_i,
  input  logic [NCH*TAP_W-1:0] pat_i,
  output logic                 out_valid,
  output logic [CW-1:0]        out_chan,
  output logic [TAP_W-1:0]     out_pat
);
  xfer_mode_e mode;

  logic [NCH-1:0]   sv_q;
  logic [CW-1:0]    sc_q [NCH];
  logic [TAP_W-1:0] sp_q [NCH];

  always_comb begin
    if (load_en)      mode = XFER_LOAD;
    else if (slow_en) mode = XFER_SHIFT;
    else              mode = XFER_HOLD;
  end

  // slot 0 faces the encoder; the last slot refills with empties
  always_ff @(posedge clk) begin
    if (rst) begin
      sv_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        sc_q[i] <= '0;
        sp_q[i] <= '0;
      end
    end else begin
      case (mode)
        XFER_LOAD: begin
          for (int i = 0; i < NCH; i++) begin
            sv_q[i] <= frozen_i[i];
            sc_q[i] <= CW'(i);
            sp_q[i] <= pat_i[i*TAP_W +: TAP_W];
          end
        end
        XFER_SHIFT: begin
          for (int i = 0; i < NCH; i++) begin
            if (i == NCH - 1) begin
              sv_q[i] <= 1'b0;
              sc_q[i] <= '0;
              sp_q[i] <= '0;
            end else begin
              sv_q[i] <= sv_q[i+1];
              sc_q[i] <= sc_q[i+1];
              sp_q[i] <= sp_q[i+1];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_pat   <= '0;
    end else if (mode != XFER_HOLD) begin
      out_valid <= sv_q[0];
      if (sv_q[0]) begin
        out_chan <= sc_q[0];
        out_pat  <= sp_q[0];
      end
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hit_share_seq.sv
module hit_share_seq
  import hit_share_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int TAP_W = 16,
  parameter int RATIO = 4,
  localparam int CW   = safe_clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       hit_i,
  input  logic [NCH*TAP_W-1:0] taps_i,
  output logic                 out_valid,
  output logic [CW-1:0]        out_chan,
  output logic [TAP_W-1:0]     out_pat
);
  localparam int FRAME = NCH * RATIO;

  logic                 slow_en;
  logic                 load_en;
  logic [NCH-1:0]       samp_open;
  logic [NCH-1:0]       samp_frozen;
  logic [NCH*TAP_W-1:0] samp_pat;

  hit_share_phase #(.NCH(NCH), .RATIO(RATIO)) u_phase (
    .clk(clk), .rst(rst), .slow_en(slow_en), .load_en(load_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    hit_share_sampler #(.TAP_W(TAP_W), .FRAME(FRAME)) u_samp (
      .clk     (clk),
      .rst     (rst),
      .hit_i   (hit_i[c]),
      .taps_i  (taps_i[c*TAP_W +: TAP_W]),
      .open_o  (samp_open[c]),
      .frozen_o(samp_frozen[c]),
      .pat_o   (samp_pat[c*TAP_W +: TAP_W])
    );
  end

  hit_share_chain #(.NCH(NCH), .TAP_W(TAP_W), .CW(CW)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .slow_en  (slow_en),
    .load_en  (load_en),
    .frozen_i (samp_frozen),
    .pat_i    (samp_pat),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .out_pat  (out_pat)
  );
endmodule

// File: rtl/hit_share_seq_chk.sv
module hit_share_seq_chk #(
  parameter int NCH   = 4,
  parameter int TAP_W = 16,
  parameter int RATIO = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 out_valid,
  input logic [NCH-1:0]       samp_open,
  input logic [NCH*TAP_W-1:0] samp_pat
);
  localparam int FRAME = NCH * RATIO;
  localparam int LW    = $clog2(FRAME + 1) + 1;
  localparam int GW    = $clog2(RATIO + 1) + 1;

  logic [GW-1:0] gap_q;
  logic [LW-1:0] shut_q [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GW'(RATIO);
    end else if (out_valid) begin
      gap_q <= '0;
    end else if (gap_q < GW'(RATIO)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst || samp_open[c]) shut_q[c] <= '0;
      else if (shut_q[c] < LW'(FRAME)) shut_q[c] <= shut_q[c] + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R1

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R6

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> gap_q >= GW'(RATIO - 1)); // R5

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_FREEZE_LEN: assert property (@(posedge clk) disable iff (rst)
      $rose(samp_open[c]) |-> shut_q[c] == LW'(FRAME - 1)); // R2

    AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (rst)
      !$past(samp_open[c]) |-> $stable(samp_pat[c*TAP_W +: TAP_W])); // R3
  end
endmodule

bind hit_share_seq hit_share_seq_chk #(.NCH(NCH), .TAP_W(TAP_W), .RATIO(RATIO)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .out_valid(out_valid),
  .samp_open(samp_open),
  .samp_pat (samp_pat)
);

// File: tb/hit_share_seq_tb.sv
`timescale 1ns/1ps
module hit_share_seq_tb;
  localparam int NCH   = 4;
  localparam int TAP_W = 16;
  localparam int RATIO = 4;
  localparam int FRAME = NCH * RATIO;

  typedef struct packed {
    logic [1:0]  ch;
    logic [3:0]  phase;
    logic [15:0] pat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{ch: 2'd0, phase: 4'd0,  pat: 16'h00FF},
    '{ch: 2'd1, phase: 4'd15, pat: 16'h0F0F},
    '{ch: 2'd2, phase: 4'd14, pat: 16'h3333},
    '{ch: 2'd3, phase: 4'd1,  pat: 16'h5555},
    '{ch: 2'd3, phase: 4'd7,  pat: 16'hFFFE},
    '{ch: 2'd2, phase: 4'd8,  pat: 16'h0001},
    '{ch: 2'd1, phase: 4'd3,  pat: 16'h8000},
    '{ch: 2'd0, phase: 4'd12, pat: 16'h7FF0}
  };

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NCH-1:0]       hit_i = '0;
  logic [NCH*TAP_W-1:0] taps_i = '0;
  logic                 out_valid;
  logic [1:0]           out_chan;
  logic [TAP_W-1:0]     out_pat;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int npulse   = 0;
  int rec_edge [8];
  int rec_ch   [8];
  int rec_pat  [8];
  bit done     = 1'b0;

  always #5 clk = ~clk;

  hit_share_seq #(.NCH(NCH), .TAP_W(TAP_W), .RATIO(RATIO)) u_dut (
    .clk(clk), .rst(rst), .hit_i(hit_i), .taps_i(taps_i),
    .out_valid(out_valid), .out_chan(out_chan), .out_pat(out_pat)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (npulse < 8) begin
        rec_edge[npulse] = cyc - 1;
        rec_ch[npulse]   = int'(out_chan);
        rec_pat[npulse]  = int'(out_pat);
      end
      npulse = npulse + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // R4/R5: first load edge after capture, then one slow cycle per slot position
  function automatic int emit_edge(input int k, input int c);
    int ld;
    ld = (k % FRAME == FRAME - 1) ? k + FRAME : k - (k % FRAME) + FRAME - 1;
    return ld + RATIO * (c + 1);
  endfunction

  task automatic wait_phase(input int ph);
    do @(negedge clk); while (cyc % FRAME != ph);
  endtask

  task automatic drive(input int c, input int pat);
    hit_i[c] = 1'b1;
    taps_i[c*TAP_W +: TAP_W] = TAP_W'(pat);
  endtask

  task automatic release_ch(input int c, input int pat);
    hit_i[c] = 1'b0;
    taps_i[c*TAP_W +: TAP_W] = ~TAP_W'(pat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 strobe in reset", int'(out_valid), 0);
    check(out_chan == '0, "R1 chan in reset", int'(out_chan), 0);
    check(out_pat == '0, "R1 pattern in reset", int'(out_pat), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 strobe after release", int'(out_valid), 0);

    // R7: no hits, no strobes
    npulse = 0;
    repeat (4 * FRAME) @(negedge clk);
    check(npulse == 0, "R7 quiet channels", npulse, 0);

    // table walk: single hits at chosen phases (R2 R3 R4 R5 R6)
    for (int v = 0; v < 8; v++) begin
      int k;
      wait_phase(int'(VECS[v].phase));
      npulse = 0;
      k = cyc;
      drive(int'(VECS[v].ch), int'(VECS[v].pat));
      @(negedge clk);
      release_ch(int'(VECS[v].ch), int'(VECS[v].pat));
      repeat (3 * FRAME) @(negedge clk);
      check(npulse == 1, "R4 loaded once", npulse, 1);
      check(rec_edge[0] == emit_edge(k, int'(VECS[v].ch)), "R5 emit edge",
            rec_edge[0], emit_edge(k, int'(VECS[v].ch)));
      check(rec_ch[0] == int'(VECS[v].ch), "R6 channel", rec_ch[0], int'(VECS[v].ch));
      check(rec_pat[0] == int'(VECS[v].pat), "R3 pattern", rec_pat[0], int'(VECS[v].pat));
    end

    // R8: all channels together
    begin
      int k;
      wait_phase(3);
      npulse = 0;
      k = cyc;
      for (int c = 0; c < NCH; c++) drive(c, 16'hA000 + c * 16'h0111);
      @(negedge clk);
      for (int c = 0; c < NCH; c++) release_ch(c, 16'hA000 + c * 16'h0111);
      repeat (3 * FRAME) @(negedge clk);
      check(npulse == NCH, "R8 all reported", npulse, NCH);
      for (int c = 0; c < NCH; c++) begin
        check(rec_edge[c] == emit_edge(k, c), "R8 slot edge", rec_edge[c], emit_edge(k, c));
        check(rec_ch[c] == c, "R5 ascending order", rec_ch[c], c);
        check(rec_pat[c] == 16'hA000 + c * 16'h0111, "R8 pattern", rec_pat[c],
              16'hA000 + c * 16'h0111);
      end
    end

    // R2: re-hit one edge before reopening is ignored
    begin
      int k;
      wait_phase(5);
      npulse = 0;
      k = cyc;
      drive(2, 16'h1234);
      @(negedge clk);
      release_ch(2, 16'h1234);
      repeat (14) @(negedge clk);
      drive(2, 16'hBEEF);
      @(negedge clk);
      release_ch(2, 16'hBEEF);
      repeat (4 * FRAME) @(negedge clk);
      check(npulse == 1, "R2 early re-hit ignored", npulse, 1);
      check(rec_pat[0] == 16'h1234, "R2 first pattern kept", rec_pat[0], 16'h1234);
      check(rec_edge[0] == emit_edge(k, 2), "R2 emit edge", rec_edge[0], emit_edge(k, 2));
    end

    // R2: re-hit exactly one frame later is captured
    begin
      int k;
      wait_phase(9);
      npulse = 0;
      k = cyc;
      drive(1, 16'h4321);
      @(negedge clk);
      release_ch(1, 16'h4321);
      repeat (15) @(negedge clk);
      drive(1, 16'hCAFE);
      @(negedge clk);
      release_ch(1, 16'hCAFE);
      repeat (4 * FRAME) @(negedge clk);
      check(npulse == 2, "R2 frame re-hit captured", npulse, 2);
      check(rec_pat[0] == 16'h4321, "R2 first of pair", rec_pat[0], 16'h4321);
      check(rec_pat[1] == 16'hCAFE, "R2 second of pair", rec_pat[1], 16'hCAFE);
      check(rec_edge[1] == emit_edge(k + FRAME, 1), "R4 second emit edge",
            rec_edge[1], emit_edge(k + FRAME, 1));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1..R8 run actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule